// File: doc/BRIEF.md
# Register Stack Frame Mapper

The block maps the logical stacked general registers of a procedure onto a finite pool of physical registers. The pool is used as a circular stack of procedure frames, and each frame has its own size. Logical registers 0 to 31 are static and pass through unchanged. Logical registers from 32 upward are taken relative to the base of the current frame and wrap around the pool.

Three commands drive the block:
- A call opens a new frame whose first registers are the caller's outgoing registers.
- An alloc resizes the current frame.
- A return brings back the caller's frame.

The sizes of every saved caller frame are kept on a small internal stack. When an alloc needs more free registers than the pool has, the block stalls and asks an external memory engine to spill the oldest saved registers, one register per handshake. When a return finds that some of the caller's local registers were spilled, it asks the engine to fill them back before the return completes.

The controller has three states:
- `ST_IDLE` accepts commands. It finishes a command directly, or moves to `ST_SPILL` when an alloc does not fit and to `ST_FILL` when a return needs registers back.
- `ST_SPILL` issues one spill request per acknowledged register. It goes back to `ST_IDLE` and finishes the alloc once the new frame fits.
- `ST_FILL` issues fill requests. It goes back to `ST_IDLE` and finishes the return once all of the caller's local registers are resident.

Top module: `regstack_mapper`

## Requirements
- R1: After reset the current frame has size 0 and `cmd_ready` is 1. `sp_req`, `cmd_done` and `cmd_bad` are 0. Logical registers 0 to 31 map to themselves, and every logical register from 32 upward is flagged illegal.
- R2: A logical register r below 32 gives `pr_idx` = r. A register r of 32 or more inside the frame gives `pr_idx` = 32 + ((base + r - 32) mod POOL) with `pr_bad` = 0.
- R3: A logical register r of 32 or more with r - 32 not less than the current frame size raises `pr_bad`.
- R4: An alloc (`cmd_op` = 1) sets the frame size to `cmd_sof` and the local count to `cmd_sol`. It is rejected with a `cmd_bad` pulse, and the frame is left unchanged, when `cmd_sof` exceeds MAXF or `cmd_sol` exceeds `cmd_sof`.
- R5: A call (`cmd_op` = 2) moves the base up by the local count, modulo POOL. The new frame keeps only the caller's outgoing registers and has no locals, so caller register 32 + locals + k and callee register 32 + k map to the same physical register.
- R6: A return (`cmd_op` = 3) restores the caller's base, frame size and local count. A return with no saved frame is rejected with `cmd_bad`.
- R7: A call made while FDEPTH caller frames are already saved is rejected with `cmd_bad`, and the frame is left unchanged.
- R8: An alloc whose new size plus the number of resident saved registers exceeds POOL stalls, with `cmd_ready` low. While stalled it issues spill requests (`sp_fill` = 0) at index 32 + ((base - resident) mod POOL), where resident is the current count of resident saved registers. Each `sp_ack` removes one resident register, and the alloc completes once the frame fits.
- R9: A return whose caller local count exceeds the resident saved count issues fill requests (`sp_fill` = 1) at index 32 + ((base - resident - 1) mod POOL). Each `sp_ack` adds one resident register, and the return completes once all caller locals are resident.
- R10: A spill or fill request that is not acknowledged stays asserted with the same `sp_idx` and `sp_fill` in the next cycle.
- R11: Each accepted command ends with exactly one single-cycle pulse, either `cmd_done` or `cmd_bad`. Both pulses are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 0 none, 1 alloc, 2 call, 3 return |
| cmd_sof | input | 7 | Requested frame size for alloc |
| cmd_sol | input | 7 | Requested local count for alloc |
| cmd_ready | output | 1 | Controller idle and accepting commands |
| cmd_done | output | 1 | Command completed (pulse) |
| cmd_bad | output | 1 | Command rejected (pulse) |
| lr_num | input | 7 | Logical register to translate |
| pr_idx | output | XW | Physical register index |
| pr_bad | output | 1 | Logical register outside the current frame |
| sp_req | output | 1 | Spill or fill request to the memory engine |
| sp_fill | output | 1 | 1 for fill, 0 for spill |
| sp_idx | output | XW | Physical register to move |
| sp_ack | input | 1 | Engine moved the requested register |

## Verification
The hardest case to reach is a return that needs fills. Getting there takes several nested calls, each followed by a large alloc that pushes older caller locals out of the pool, before the stack is unwound. The bench builds such a stack on purpose, up to the full frame-stack depth, and then returns through every level. It also runs a long random mix of commands with random acknowledge delays, so that spills and fills happen at many base and resident-count positions around the wrap of the pool.

// File: rtl/rsm_pkg.sv
package rsm_pkg;
    localparam int NSTAT = 32;   // static registers below the stacked window
    localparam int SW    = 7;    // width of frame size and local count

    typedef enum logic [1:0] {
        OP_NOP   = 2'd0,
        OP_ALLOC = 2'd1,
        OP_CALL  = 2'd2,
        OP_RET   = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SPILL,
        ST_FILL
    } st_e;

    typedef struct packed {
        logic [SW-1:0] sof;
        logic [SW-1:0] sol;
    } frame_t;
endpackage

// File: rtl/rsm_frame_stack.sv
module rsm_frame_stack
    import rsm_pkg::*;
#(
    parameter int FDEPTH = 8
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   push,
    input  logic   pop,
    input  frame_t din,
    output frame_t top,
    output logic   empty,
    output logic   full
);
    localparam int CW  = $clog2(FDEPTH + 1);
    localparam int IXW = $clog2(FDEPTH);

    frame_t         ent [FDEPTH];
    logic [CW-1:0]  cnt_q;
    logic [CW-1:0]  tix;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < FDEPTH; i++) ent[i] <= '0;
        end else begin
            if (push && !full) begin
                ent[cnt_q[IXW-1:0]] <= din;
                cnt_q <= cnt_q + 1'b1;
            end else if (pop && !empty) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign tix   = cnt_q - 1'b1;
    assign top   = ent[tix[IXW-1:0]];
    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CW'(FDEPTH));

    // R7: the controller never pushes onto a full stack
    p_push_room_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R6: the controller never pops an empty stack
    p_pop_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    p_depth_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(FDEPTH));
endmodule

// File: rtl/rsm_xlate.sv
module rsm_xlate
    import rsm_pkg::*;
#(
    parameter int POOL = 128,
    localparam int IW  = $clog2(POOL),
    localparam int XW  = $clog2(NSTAT + POOL)
) (
    input  logic [6:0]    lr,
    input  logic [IW-1:0] bof,
    input  logic [SW-1:0] sof,
    output logic [XW-1:0] pidx,
    output logic          bad
);
    localparam int AW = $clog2(POOL + 1) + 1;

    logic          in_stk;
    logic [SW-1:0] off;
    logic [AW-1:0] sum;
    logic [IW-1:0] pos;

    always_comb begin
        in_stk = (lr >= 7'(NSTAT));
        off    = lr - 7'(NSTAT);
        sum    = AW'(bof) + AW'(off);
        if (sum >= AW'(POOL)) sum = sum - AW'(POOL);
        pos    = sum[IW-1:0];
        bad    = in_stk && (off >= sof);
        pidx   = in_stk ? (XW'(NSTAT) + XW'(pos)) : XW'(lr);
    end
endmodule

// File: rtl/rsm_ctrl.sv
module rsm_ctrl
    import rsm_pkg::*;
#(
    parameter int POOL   = 128,
    parameter int MAXF   = 96,
    parameter int FDEPTH = 8,
    localparam int IW    = $clog2(POOL),
    localparam int XW    = $clog2(NSTAT + POOL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [SW-1:0] cmd_sof,
    input  logic [SW-1:0] cmd_sol,
    output logic          cmd_ready,
    output logic          cmd_done,
    output logic          cmd_bad,
    output logic          sp_req,
    output logic          sp_fill,
    output logic [XW-1:0] sp_idx,
    input  logic          sp_ack,
    output logic [IW-1:0] bof,
    output logic [SW-1:0] sof,
    output logic          stk_push,
    output logic          stk_pop,
    output frame_t        stk_din,
    input  frame_t        stk_top,
    input  logic          stk_empty,
    input  logic          stk_full
);
    localparam int DW = $clog2(POOL + 1);
    localparam int AW = DW + 1;

    function automatic logic [IW-1:0] mod_add(input logic [IW-1:0] a, input logic [DW-1:0] b);
        logic [AW-1:0] s;
        s = AW'(a) + AW'(b);
        if (s >= AW'(POOL)) s = s - AW'(POOL);
        return s[IW-1:0];
    endfunction

    function automatic logic [IW-1:0] mod_sub(input logic [IW-1:0] a, input logic [DW-1:0] b);
        logic [AW-1:0] s;
        s = AW'(a) + AW'(POOL) - AW'(b);
        if (s >= AW'(POOL)) s = s - AW'(POOL);
        return s[IW-1:0];
    endfunction

    st_e           st_q, st_d;
    logic [IW-1:0] bof_q;
    logic [SW-1:0] sof_q, sol_q, psof_q, psol_q;
    logic [DW-1:0] res_q;          // resident saved registers below the base
    logic          done_q, bad_q;

    logic          c_alloc, c_call, c_ret, c_bad, latch_pend;
    logic          spill_step, fill_step;
    logic [SW-1:0] a_sof, a_sol;
    logic [IW-1:0] spill_pos, fill_pos, req_pos;
    logic          need_spill_cmd, need_spill_pend, need_fill;

    assign spill_pos       = mod_sub(bof_q, res_q);
    assign fill_pos        = mod_sub(bof_q, DW'(res_q + 1'b1));
    assign need_spill_cmd  = (AW'(res_q) + AW'(cmd_sof)) > AW'(POOL);
    assign need_spill_pend = (AW'(res_q) + AW'(psof_q)) > AW'(POOL);
    assign need_fill       = (AW'(res_q) < AW'(stk_top.sol));

    // next state and command decode
    always_comb begin
        st_d       = st_q;
        c_alloc    = 1'b0;
        c_call     = 1'b0;
        c_ret      = 1'b0;
        c_bad      = 1'b0;
        latch_pend = 1'b0;
        spill_step = 1'b0;
        fill_step  = 1'b0;
        sp_req     = 1'b0;
        sp_fill    = 1'b0;
        req_pos    = spill_pos;
        a_sof      = cmd_sof;
        a_sol      = cmd_sol;
        unique case (st_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    unique case (op_e'(cmd_op))
                        OP_ALLOC: begin
                            if (cmd_sof > SW'(MAXF) || cmd_sol > cmd_sof) begin
                                c_bad = 1'b1;
                            end else if (need_spill_cmd) begin
                                latch_pend = 1'b1;
                                st_d       = ST_SPILL;
                            end else begin
                                c_alloc = 1'b1;
                            end
                        end
                        OP_CALL: begin
                            if (stk_full) c_bad = 1'b1;
                            else          c_call = 1'b1;
                        end
                        OP_RET: begin
                            if (stk_empty)      c_bad = 1'b1;
                            else if (need_fill) st_d  = ST_FILL;
                            else                c_ret = 1'b1;
                        end
                        OP_NOP: ;
                    endcase
                end
            end
            ST_SPILL: begin
                a_sof = psof_q;
                a_sol = psol_q;
                if (need_spill_pend) begin
                    sp_req     = 1'b1;
                    req_pos    = spill_pos;
                    spill_step = sp_ack;
                end else begin
                    c_alloc = 1'b1;
                    st_d    = ST_IDLE;
                end
            end
            ST_FILL: begin
                if (need_fill) begin
                    sp_req    = 1'b1;
                    sp_fill   = 1'b1;
                    req_pos   = fill_pos;
                    fill_step = sp_ack;
                end else begin
                    c_ret = 1'b1;
                    st_d  = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // frame state and output pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bof_q  <= '0;
            sof_q  <= '0;
            sol_q  <= '0;
            res_q  <= '0;
            psof_q <= '0;
            psol_q <= '0;
            done_q <= 1'b0;
            bad_q  <= 1'b0;
        end else begin
            done_q <= c_alloc | c_call | c_ret;
            bad_q  <= c_bad;
            if (latch_pend) begin
                psof_q <= cmd_sof;
                psol_q <= cmd_sol;
            end
            if (c_alloc) begin
                sof_q <= a_sof;
                sol_q <= a_sol;
            end
            if (c_call) begin
                bof_q <= mod_add(bof_q, DW'(sol_q));
                res_q <= res_q + DW'(sol_q);
                sof_q <= sof_q - sol_q;
                sol_q <= '0;
            end
            if (c_ret) begin
                bof_q <= mod_sub(bof_q, DW'(stk_top.sol));
                res_q <= res_q - DW'(stk_top.sol);
                sof_q <= stk_top.sof;
                sol_q <= stk_top.sol;
            end
            if (spill_step) res_q <= res_q - 1'b1;
            if (fill_step)  res_q <= res_q + 1'b1;
        end
    end

    assign cmd_ready = (st_q == ST_IDLE);
    assign cmd_done  = done_q;
    assign cmd_bad   = bad_q;
    assign sp_idx    = XW'(NSTAT) + XW'(req_pos);
    assign bof       = bof_q;
    assign sof       = sof_q;
    assign stk_push  = c_call;
    assign stk_pop   = c_ret;
    assign stk_din   = '{sof: sof_q, sol: sol_q};

    // R10: an unanswered request holds its index and direction
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_req && !sp_ack) |=> (sp_req && $stable(sp_idx) && $stable(sp_fill)));
    // R8: whenever idle, frame plus resident saved registers fit the pool
    p_pool_fit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> ((AW'(res_q) + AW'(sof_q)) <= AW'(POOL)));
    // R8: commands are held off while the engine is busy
    p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sp_req |-> !cmd_ready);
    // R11: never both outcomes at once
    p_one_outcome_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_done, cmd_bad}));
    // R4: a committed frame always respects the size limits
    p_frame_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_q <= SW'(MAXF)) && (sol_q <= sof_q));
    // R9: fills only during a return
    p_fill_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_req && sp_fill) |-> (st_q == ST_FILL));
endmodule

// File: rtl/regstack_mapper.sv
module regstack_mapper
    import rsm_pkg::*;
#(
    parameter int POOL   = 128,
    parameter int MAXF   = 96,
    parameter int FDEPTH = 8,
    localparam int XW    = $clog2(NSTAT + POOL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [6:0]    cmd_sof,
    input  logic [6:0]    cmd_sol,
    output logic          cmd_ready,
    output logic          cmd_done,
    output logic          cmd_bad,
    input  logic [6:0]    lr_num,
    output logic [XW-1:0] pr_idx,
    output logic          pr_bad,
    output logic          sp_req,
    output logic          sp_fill,
    output logic [XW-1:0] sp_idx,
    input  logic          sp_ack
);
    localparam int IW = $clog2(POOL);

    logic [IW-1:0] bof;
    logic [SW-1:0] sof;
    logic          stk_push, stk_pop, stk_empty, stk_full;
    frame_t        stk_din, stk_top;

    rsm_ctrl #(.POOL(POOL), .MAXF(MAXF), .FDEPTH(FDEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_sof   (cmd_sof),
        .cmd_sol   (cmd_sol),
        .cmd_ready (cmd_ready),
        .cmd_done  (cmd_done),
        .cmd_bad   (cmd_bad),
        .sp_req    (sp_req),
        .sp_fill   (sp_fill),
        .sp_idx    (sp_idx),
        .sp_ack    (sp_ack),
        .bof       (bof),
        .sof       (sof),
        .stk_push  (stk_push),
        .stk_pop   (stk_pop),
        .stk_din   (stk_din),
        .stk_top   (stk_top),
        .stk_empty (stk_empty),
        .stk_full  (stk_full)
    );

    rsm_frame_stack #(.FDEPTH(FDEPTH)) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (stk_push),
        .pop   (stk_pop),
        .din   (stk_din),
        .top   (stk_top),
        .empty (stk_empty),
        .full  (stk_full)
    );

    rsm_xlate #(.POOL(POOL)) u_xlate (
        .lr   (lr_num),
        .bof  (bof),
        .sof  (sof),
        .pidx (pr_idx),
        .bad  (pr_bad)
    );

    // R2: a legal stacked register lands inside the physical stacked window
    p_map_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pr_bad && lr_num >= 7'(NSTAT)) |->
        (pr_idx >= XW'(NSTAT) && pr_idx < XW'(NSTAT + POOL)));
    // R2: static registers pass straight through
    p_static_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lr_num < 7'(NSTAT)) |-> (pr_idx == XW'(lr_num) && !pr_bad));
    // R8: requests always name a stacked physical register
    p_req_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sp_req |-> (sp_idx >= XW'(NSTAT) && sp_idx < XW'(NSTAT + POOL)));
endmodule

// File: tb/regstack_mapper_tb.sv
module regstack_mapper_tb;
    localparam int POOL = 128;
    localparam int MAXF = 96;
    localparam int FD   = 8;
    localparam int XW   = $clog2(32 + POOL);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'd0;
    logic [6:0]    cmd_sof = '0, cmd_sol = '0;
    logic          cmd_ready, cmd_done, cmd_bad;
    logic [6:0]    lr_num = '0;
    logic [XW-1:0] pr_idx, sp_idx;
    logic          pr_bad, sp_req, sp_fill;
    logic          sp_ack = 1'b0;

    int nchk = 0, nerr = 0;
    int m_bof = 0, m_sof = 0, m_sol = 0, m_res = 0, m_depth = 0;
    int ssof [FD];
    int ssol [FD];

    always #5 clk = ~clk;

    regstack_mapper #(.POOL(POOL), .MAXF(MAXF), .FDEPTH(FD)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_sof(cmd_sof), .cmd_sol(cmd_sol), .cmd_ready(cmd_ready),
        .cmd_done(cmd_done), .cmd_bad(cmd_bad), .lr_num(lr_num),
        .pr_idx(pr_idx), .pr_bad(pr_bad), .sp_req(sp_req), .sp_fill(sp_fill),
        .sp_idx(sp_idx), .sp_ack(sp_ack)
    );

    function automatic int wrapm(input int x);
        return ((x % POOL) + POOL) % POOL;
    endfunction

    function automatic int exp_pidx(input int r);
        return (r < 32) ? r : 32 + wrapm(m_bof + r - 32);
    endfunction

    function automatic bit exp_bad(input int r);
        return (r >= 32) && (r - 32 >= m_sof);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_map(input int r, input string tag);
        lr_num = 7'(r);
        #1;
        check(pr_bad == exp_bad(r), {tag, " pr_bad"}, int'(pr_bad), int'(exp_bad(r)));
        if (!exp_bad(r))
            check(int'(pr_idx) == exp_pidx(r), {tag, " pr_idx"}, int'(pr_idx), exp_pidx(r));
    endtask

    task automatic chk_frame(input string tag);
        chk_map($urandom_range(0, 31), {tag, " R2 static"});
        chk_map(32, {tag, " R2/R3 first"});
        if (m_sof > 0) chk_map(31 + m_sof, {tag, " R2 last"});
        if (m_sof < 96) chk_map(32 + m_sof, {tag, " R3 beyond"});
        chk_map($urandom_range(32, 127), {tag, " R2/R3 random"});
    endtask

    // issue one command, serve the engine handshake, update the model
    task automatic run_cmd(input int op, input int s, input int l, input string tag);
        bit xbad;
        int res0, xsteps, nsteps, n, csof, csol;
        xbad = 0; xsteps = 0; nsteps = 0; n = 0; csof = 0; csol = 0;
        res0 = m_res;
        if (m_depth > 0) begin
            csof = ssof[m_depth-1];
            csol = ssol[m_depth-1];
        end
        case (op)
            1: begin
                xbad = (s > MAXF) || (l > s);
                if (!xbad && m_res + s > POOL) xsteps = m_res + s - POOL;
            end
            2: xbad = (m_depth == FD);
            3: begin
                xbad = (m_depth == 0);
                if (!xbad && csol > m_res) xsteps = csol - m_res;
            end
            default: ;
        endcase
        @(negedge clk);
        #1;
        check(cmd_ready == 1'b1, {tag, " R11 ready before command"}, int'(cmd_ready), 1);
        cmd_valid = 1'b1; cmd_op = 2'(op); cmd_sof = 7'(s); cmd_sol = 7'(l);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'd0;
        forever begin
            #1;
            if (cmd_done || cmd_bad) break;
            if (sp_req) begin
                if (op == 1) begin
                    check(m_res + s > POOL, {tag, " R8 spill needed"}, m_res + s, POOL);
                    check(sp_fill == 1'b0, {tag, " R8 spill direction"}, int'(sp_fill), 0);
                    check(int'(sp_idx) == 32 + wrapm(m_bof - m_res),
                          {tag, " R8/R10 spill index"}, int'(sp_idx), 32 + wrapm(m_bof - m_res));
                end else begin
                    check(op == 3 && csol > m_res, {tag, " R9 fill needed"}, op, 3);
                    check(sp_fill == 1'b1, {tag, " R9 fill direction"}, int'(sp_fill), 1);
                    check(int'(sp_idx) == 32 + wrapm(m_bof - m_res - 1),
                          {tag, " R9/R10 fill index"}, int'(sp_idx), 32 + wrapm(m_bof - m_res - 1));
                end
                check(cmd_ready == 1'b0, {tag, " R8 stall"}, int'(cmd_ready), 0);
                if ($urandom_range(0, 2) != 0) begin
                    sp_ack = 1'b1;
                    nsteps++;
                    m_res = m_res + ((op == 1) ? -1 : 1);
                end
            end
            n++;
            if (n > 2000) begin
                check(0, {tag, " R11 command never finished"}, n, 0);
                break;
            end
            @(negedge clk);
            sp_ack = 1'b0;
        end
        check(cmd_bad == xbad, {tag, " R4/R6/R7 reject"}, int'(cmd_bad), int'(xbad));
        check(cmd_done == !xbad, {tag, " R11 done"}, int'(cmd_done), int'(!xbad));
        check(nsteps == xsteps, {tag, " R8/R9 step count"}, nsteps, xsteps);
        m_res = res0;
        if (!xbad) begin
            case (op)
                1: begin
                    m_res = res0 - xsteps;
                    m_sof = s; m_sol = l;
                end
                2: begin
                    ssof[m_depth] = m_sof; ssol[m_depth] = m_sol; m_depth++;
                    m_bof = wrapm(m_bof + m_sol);
                    m_res = res0 + m_sol;
                    m_sof = m_sof - m_sol; m_sol = 0;
                end
                3: begin
                    m_res = res0 + xsteps - csol;
                    m_bof = wrapm(m_bof - csol);
                    m_sof = csof; m_sol = csol; m_depth--;
                end
                default: ;
            endcase
        end
        @(negedge clk);
        #1;
        check(!cmd_done && !cmd_bad, {tag, " R11 single pulse"}, int'(cmd_done | cmd_bad), 0);
        chk_frame(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++; nchk++;
        $display("FAIL watchdog R11 actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        int keep [8];
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1 reset state
        check(cmd_ready == 1'b1, "R1 ready", int'(cmd_ready), 1);
        check(!sp_req && !cmd_done && !cmd_bad, "R1 quiet outputs",
              int'({sp_req, cmd_done, cmd_bad}), 0);
        chk_map(5, "R1 static");
        chk_map(32, "R1 stacked illegal");
        chk_map(127, "R1 top illegal");

        // R4/R6 rejections leave the frame unchanged
        run_cmd(1, 100, 0, "R4 oversize alloc");
        run_cmd(1, 10, 12, "R4 locals exceed size");
        run_cmd(3, 0, 0, "R6 return empty");

        // R5 overlap of caller outputs with callee inputs
        run_cmd(1, 20, 12, "R4 alloc 20/12");
        for (int k = 0; k < 8; k++) keep[k] = exp_pidx(44 + k);
        run_cmd(2, 0, 0, "R5 call");
        for (int k = 0; k < 8; k++) begin
            lr_num = 7'(32 + k);
            #1;
            check(int'(pr_idx) == keep[k], "R5 overlap", int'(pr_idx), keep[k]);
        end
        run_cmd(3, 0, 0, "R6 return");
        check(m_sof == 20, "R6 model size", m_sof, 20);

        // deep nesting with spills, full stack, then unwind with fills
        for (int d = 0; d < FD; d++) begin
            run_cmd(1, 96, 40, "R8 big alloc");
            run_cmd(2, 0, 0, "R5 nested call");
        end
        run_cmd(2, 0, 0, "R7 call on full stack");
        run_cmd(1, 96, 30, "R8 alloc at depth");
        for (int d = 0; d < FD; d++) run_cmd(3, 0, 0, "R9 unwind return");
        run_cmd(3, 0, 0, "R6 return after unwind");

        // random mix
        for (int i = 0; i < 400; i++) begin
            int op, s, l;
            op = $urandom_range(1, 3);
            s = $urandom_range(0, 96);
            l = $urandom_range(0, s);
            if ($urandom_range(0, 9) == 0) s = $urandom_range(97, 127);
            if ($urandom_range(0, 9) == 0) l = s + 1;
            run_cmd(op, s, l, "R2-mix random");
        end

        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule